// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and an external ROM plus an optional RAM. Processor writes that land in the ROM address space never reach the ROM. The block treats them as control writes instead. These writes choose which 16 KB ROM bank appears in the upper half of the ROM space, which 8 KB RAM bank appears in the external RAM window, and whether the RAM can be used at all.

From the current bus address and these registers, the block forms the physical ROM and RAM addresses with no added delay. It raises the RAM write strobe only when the RAM path is usable. It also steers read data back to the processor, returning 0xFF whenever the RAM is switched off, not fitted, or replaced by a clock-register selection. The clock registers are not modelled. Their select codes and the latch window are accepted and do nothing. RAM write data is taken straight from the bus.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and RAM is disabled. A read at 0x4000 then gives ROM address 0x04000, and a read at 0xA000 returns 0xFF.
- R2: Bus addresses 0x0000–0x3FFF drive the ROM address equal to the bus address, whatever the bank register holds.
- R3: Bus addresses 0x4000–0x7FFF drive the ROM address (addr − 0x4000) + 0x4000 × bank, modulo ROM_BANKS × 16 KB.
- R4: A write to 0x2000–0x3FFF loads the ROM bank from data bits 6:0. A value of 0 is stored as 1.
- R5: A write to 0x0000–0x1FFF sets the RAM enable when data bits 3:0 equal 0xA. Any other low nibble clears it.
- R6: A write to 0x4000–0x5FFF with data 0x00–0x03 selects that RAM bank. Bus addresses 0xA000–0xBFFF then drive the RAM address (addr − 0xA000) + 0x2000 × bank, modulo RAM_BYTES.
- R7: A write of 0x08–0x0C to 0x4000–0x5FFF makes the RAM path inactive: reads return 0xFF and ram_we stays low. A later select of 0x00–0x03 makes it active again.
- R8: A write to 0x4000–0x5FFF with any data outside 0x00–0x03 and 0x08–0x0C changes nothing.
- R9: Writes to 0x6000–0x7FFF change no register.
- R10: While the RAM path is active, reads in 0xA000–0xBFFF return ram_rdata and writes there assert ram_we. When RAM is disabled or RAM_BYTES is 0, those reads return 0xFF and ram_we stays low. Reads in 0x0000–0x7FFF always return rom_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Bus write data, also used as RAM write data |
| cpu_wr | input | 1 | Bus write strobe, one cycle per write |
| cpu_rdata | output | 8 | Read data returned to the bus |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_rdata | input | 8 | ROM read data |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM read data |

## Verification
A control write takes effect at the rising edge on which cpu_wr is high. Every address, strobe and read-data output is a combinational function of the current bus inputs and the registers, so each result is due in the same cycle the bus presents the address. The bench therefore changes inputs on the falling edge. After a write, it applies the probe address only on a later falling edge and samples shortly afterwards, before the next rising edge. This means every check sees settled register state and the combinational output that belongs to it.

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BYTES = 32768
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [15:0]                            cpu_addr,
  input  logic [7:0]                             cpu_wdata,
  input  logic                                   cpu_wr,
  output logic [7:0]                             cpu_rdata,
  output logic [$clog2(ROM_BANKS)+13:0]          rom_addr,
  input  logic [7:0]                             rom_rdata,
  output logic [((RAM_BYTES>0)?$clog2(RAM_BYTES):1)-1:0] ram_addr,
  output logic                                   ram_we,
  input  logic [7:0]                             ram_rdata
);
  localparam int  ROM_AW  = $clog2(ROM_BANKS) + 14;
  localparam bit  HAS_RAM = (RAM_BYTES > 0);
  localparam int  RAM_AW  = HAS_RAM ? $clog2(RAM_BYTES) : 1;

  logic [6:0] rom_bank;
  logic [1:0] ram_bank;
  logic       ram_en;
  logic       clk_sel;

  wire ctl_wr   = cpu_wr && !cpu_addr[15];
  wire [6:0] bank_in = cpu_wdata[6:0];
  wire in_rom   = !cpu_addr[15];
  wire in_ram   = (cpu_addr[15:13] == 3'b101);
  wire ram_live = HAS_RAM && ram_en && !clk_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= 7'd1;
      ram_bank <= 2'd0;
      ram_en   <= 1'b0;
      clk_sel  <= 1'b0;
    end else if (ctl_wr) begin
      case (cpu_addr[14:13])
        2'b00: ram_en <= (cpu_wdata[3:0] == 4'hA);
        2'b01: rom_bank <= (bank_in == 7'd0) ? 7'd1 : bank_in;
        2'b10: begin
          if (cpu_wdata <= 8'h03) begin
            ram_bank <= cpu_wdata[1:0];
            clk_sel  <= 1'b0;
          end else if (cpu_wdata >= 8'h08 && cpu_wdata <= 8'h0C) begin
            clk_sel  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  logic [20:0] rom_full;
  logic [14:0] ram_full;
  assign rom_full = cpu_addr[14] ? {rom_bank, cpu_addr[13:0]} : {7'd0, cpu_addr[13:0]};
  assign ram_full = {ram_bank, cpu_addr[12:0]};
  assign rom_addr = rom_full[ROM_AW-1:0];
  assign ram_addr = ram_full[RAM_AW-1:0];
  assign ram_we   = cpu_wr && in_ram && ram_live;

  always_comb begin
    if (in_rom)                  cpu_rdata = rom_rdata;
    else if (in_ram && ram_live) cpu_rdata = ram_rdata;
    else                         cpu_rdata = 8'hFF;
  end

  // R2
  low_window_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (rom_addr == ROM_AW'(cpu_addr[13:0])));

  // R4
  zero_bank_is_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata[6:0] == 7'd0) |=> (rom_bank == 7'd1));

  // R5
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA) |=> !ram_en);

  // R8
  bad_select_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b010 && cpu_wdata > 8'h03 &&
     !(cpu_wdata >= 8'h08 && cpu_wdata <= 8'h0C)) |=> ($stable(ram_bank) && $stable(clk_sel)));

  // R9
  latch_window_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=>
      ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en) && $stable(clk_sel)));

  // R10
  no_write_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_en || clk_sel) |-> !ram_we);
endmodule

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [19:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_we;
  logic [7:0]  rom_rdata = 8'h5A;
  logic [7:0]  ram_rdata = 8'h3C;

  int checks = 0;
  int fails = 0;

  cart_bank_ctrl #(.ROM_BANKS(64), .RAM_BYTES(32768)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_rdata(ram_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    #1;
  endtask

  task automatic probe_write(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = 8'h77; cpu_wr = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    probe(16'h4000);
    chk("R1 rom bank", 32'(rom_addr), 32'h04000);
    probe(16'hA000);
    chk("R1 ram off", 32'(cpu_rdata), 32'hFF);
    chk("R1 ram bank", 32'(ram_addr), 32'h0000);
  endtask

  task automatic t_low_window;
    bus_write(16'h2000, 8'h05);
    probe(16'h3ABC);
    chk("R2 flat", 32'(rom_addr), 32'h03ABC);
    chk("R10 rom data", 32'(cpu_rdata), 32'h5A);
  endtask

  task automatic t_upper_window;
    probe(16'h4123);
    chk("R3 bank5", 32'(rom_addr), 32'h14123);
    bus_write(16'h3FFF, 8'h45);
    probe(16'h4123);
    chk("R3 wrap", 32'(rom_addr), 32'h14123);
    bus_write(16'h2100, 8'hC3);
    probe(16'h7FFF);
    chk("R4 low7 wrap", 32'(rom_addr), 32'h0FFFF);
  endtask

  task automatic t_zero_bank;
    bus_write(16'h2000, 8'h00);
    probe(16'h4000);
    chk("R4 zero", 32'(rom_addr), 32'h04000);
    bus_write(16'h2000, 8'h80);
    probe(16'h4001);
    chk("R4 0x80", 32'(rom_addr), 32'h04001);
  endtask

  task automatic t_enable;
    probe_write(16'hA010);
    chk("R10 we off", 32'(ram_we), 32'h0);
    cpu_wr = 1'b0;
    bus_write(16'h0000, 8'h1A);
    probe(16'hA010);
    chk("R5 set", 32'(cpu_rdata), 32'h3C);
    probe_write(16'hA010);
    chk("R10 we on", 32'(ram_we), 32'h1);
    cpu_wr = 1'b0;
    bus_write(16'h1FFF, 8'hA0);
    probe(16'hA010);
    chk("R5 clear", 32'(cpu_rdata), 32'hFF);
    bus_write(16'h1000, 8'h0A);
  endtask

  task automatic t_ram_bank;
    bus_write(16'h4000, 8'h02);
    probe(16'hA010);
    chk("R6 bank2", 32'(ram_addr), 32'h4010);
    bus_write(16'h5FFF, 8'h03);
    probe(16'hBFFF);
    chk("R6 bank3", 32'(ram_addr), 32'h7FFF);
  endtask

  task automatic t_clock_select;
    bus_write(16'h4000, 8'h0C);
    probe(16'hA000);
    chk("R7 read ff", 32'(cpu_rdata), 32'hFF);
    probe_write(16'hA000);
    chk("R7 we low", 32'(ram_we), 32'h0);
    cpu_wr = 1'b0;
    bus_write(16'h4000, 8'h01);
    probe(16'hA004);
    chk("R7 restore", 32'(cpu_rdata), 32'h3C);
    chk("R7 bank1", 32'(ram_addr), 32'h2004);
  endtask

  task automatic t_bad_select;
    bus_write(16'h4000, 8'h05);
    probe(16'hA004);
    chk("R8 keep bank", 32'(ram_addr), 32'h2004);
    bus_write(16'h4000, 8'h0D);
    probe(16'hA004);
    chk("R8 still live", 32'(cpu_rdata), 32'h3C);
  endtask

  task automatic t_latch_window;
    bus_write(16'h6000, 8'h00);
    bus_write(16'h7FFF, 8'h01);
    probe(16'h4000);
    chk("R9 rom bank", 32'(rom_addr), 32'h04000);
    probe(16'hA004);
    chk("R9 ram", 32'(cpu_rdata), 32'h3C);
    chk("R9 ram bank", 32'(ram_addr), 32'h2004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low_window();
    t_upper_window();
    t_zero_bank();
    t_enable();
    t_ram_bank();
    t_clock_select();
    t_bad_select();
    t_latch_window();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule